// File: doc/BRIEF.md
# Serial Command Frame Interface

This block is the slave side of a chip-select-framed serial link for a data converter. When the host pulls chip-select low, the block latches the current output word into a 22-bit transmit register and clears a 22-bit receive register. The all-zero value of the receive register is the no-operation command. While the frame is open, each SCLK rising edge counts one clock and shifts one SDI bit into the receive register. Each SCLK falling edge moves the transmit register on to its next bit. The frame can begin at any moment, independent of any conversion activity.

When chip-select returns high, the block closes the frame and sorts it by the number of clocks it counted:
- **Short frame** (fewer than 22 clocks): the received bits are dropped silently. The host can still use such frames to read only the upper bits of the output word.
- **Exact frame** (22 clocks): the received word is handed to the downstream command port.
- **Long frame** (more than 22 clocks): the last 22 bits received are handed to the command port.

The clock counter saturates rather than wrapping, so any frame length classifies correctly. A ready flag is low from frame start until a fixed number of system cycles after frame end. SDO is driven only while a frame is open.

All host pins are asynchronous. They are resynchronised into the system clock domain, and SCLK is oversampled there, so SCLK must be several times slower than the system clock.

Top module: `sfi_cmd_frame`

## Requirements
- R1: After reset, `rdy` is 1, `sdo_oe` is 0, `sdo` is 0 and `cmd_valid` is 0.
- R2: Within a few system cycles of chip-select falling, `sdo_oe` goes to 1 and `rdy` goes to 0. `sdo` then shows bit 21 (the MSB) of `out_word` as sampled at frame start.
- R3: Each SCLK falling edge inside a frame advances `sdo` to the next lower bit of the latched word (MSB first). Once all 22 bits have been sent, `sdo` is 0.
- R4: SDI is sampled on SCLK rising edges and shifted in MSB first: in an exact frame, the first bit received lands in bit 21 of `cmd_word`.
- R5: A frame with exactly 22 clocks produces one `cmd_valid` pulse carrying the 22 received bits.
- R6: A frame with fewer than 22 clocks produces no `cmd_valid`. The bits shifted out on `sdo` during it still follow R2 and R3.
- R7: A frame with more than 22 clocks produces one `cmd_valid` pulse carrying the last 22 bits received, in arrival order with the final bit in bit 0. This holds for frames longer than the counter range, because the counter saturates.
- R8: After chip-select rises, `sdo_oe` drops to 0 within a few cycles. `rdy` stays 0 until READY_DLY system cycles after the frame is closed, then returns to 1.
- R9: An SCLK rising edge that arrives together with chip-select rising is counted and shifted into the frame being closed.
- R10: Changes on `out_word` while a frame is open do not alter the bits shifted out in that frame.
- R11: `cmd_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip-select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdi | input | 1 | Host serial data in |
| out_word | input | 22 | Word to be transmitted, latched at frame start |
| sdo | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the SDO pad driver (high impedance when 0) |
| rdy | output | 1 | Ready flag, low during a frame and the post-frame delay |
| cmd_valid | output | 1 | One-cycle strobe: a command word is presented |
| cmd_word | output | 22 | Received command word |

## Verification
The two functions that can land in one system cycle are the capture of an SCLK rising edge and the closing of the frame. If the close used the counter's registered value, the coinciding edge would be lost and a 22-clock frame would be misjudged as short. The bench provokes this by raising SCLK and chip-select in the same time step on a 22-clock frame. A scoreboard then requires exactly one command pulse, carrying all 22 bits with the final bit in position 0. Exact, short, long and saturating frames run alongside it, so that any miscount shows up as a missing, unexpected or wrong command.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    // Frame length classes decided at frame close
    typedef enum logic [1:0] {
        FR_SHORT = 2'd0,
        FR_EXACT = 2'd1,
        FR_LONG  = 2'd2
    } frame_kind_e;

    parameter int unsigned SFI_WORD_W = 22;

endpackage

// File: rtl/sfi_sync.sv
module sfi_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    // one flop row per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= RST_VAL;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sfi_shift.sv
module sfi_shift #(
    parameter int unsigned WORD_W = 22,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              cap,
    input  logic              launch,
    input  logic              sdi,
    input  logic [WORD_W-1:0] load_word,
    output logic              sdo_bit,
    output logic [WORD_W-1:0] idr_next,
    output logic [CNT_W-1:0]  cnt_next,
    output logic [CNT_W-1:0]  cnt_q_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [WORD_W-1:0] odr;
        logic [WORD_W-1:0] idr;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.odr = load_word;
            st_d.idr = '0;
            st_d.cnt = '0;
        end else if (active) begin
            if (cap) begin
                st_d.idr = {st_q.idr[WORD_W-2:0], sdi};
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (launch) begin
                st_d.odr = {st_q.odr[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_bit  = st_q.odr[WORD_W-1];
    assign idr_next = st_d.idr;
    assign cnt_next = st_d.cnt;
    assign cnt_q_o  = st_q.cnt;

endmodule

// File: rtl/sfi_frame_ctl.sv
module sfi_frame_ctl
    import sfi_pkg::*;
#(
    parameter int unsigned WORD_W    = 22,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned READY_DLY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic [WORD_W-1:0] idr_next,
    output logic              active,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word,
    output logic              rdy
);

    localparam int unsigned       TMR_W    = (READY_DLY < 2) ? 1 : $clog2(READY_DLY + 1);
    localparam logic [CNT_W-1:0]  WORD_CNT = CNT_W'(WORD_W);
    localparam logic [TMR_W-1:0]  TMR_LOAD = TMR_W'(READY_DLY);

    typedef struct packed {
        logic              active;
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              rdy;
        logic [TMR_W-1:0]  tmr;
    } ctl_t;

    ctl_t        st_d, st_q;
    frame_kind_e kind;

    always_comb begin
        if (cnt_next < WORD_CNT)       kind = FR_SHORT;
        else if (cnt_next == WORD_CNT) kind = FR_EXACT;
        else                           kind = FR_LONG;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.rdy    = 1'b0;
            st_d.tmr    = '0;
        end else if (cs_rise && st_q.active) begin
            st_d.active = 1'b0;
            if (kind != FR_SHORT) begin
                st_d.vld  = 1'b1;
                st_d.word = idr_next;
            end
            st_d.tmr = TMR_LOAD;
            if (READY_DLY == 0) st_d.rdy = 1'b1;
        end else if (!st_q.active && !st_q.rdy) begin
            if (st_q.tmr <= TMR_W'(1)) begin
                st_d.rdy = 1'b1;
                st_d.tmr = '0;
            end else begin
                st_d.tmr = st_q.tmr - TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign cmd_valid = st_q.vld;
    assign cmd_word  = st_q.word;
    assign rdy       = st_q.rdy;

endmodule

// File: rtl/sfi_cmd_frame.sv
module sfi_cmd_frame #(
    parameter int unsigned WORD_W      = sfi_pkg::SFI_WORD_W,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned READY_DLY   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [WORD_W-1:0] out_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              rdy,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 2);

    typedef struct packed {
        logic cs;
        logic sclk;
    } edge_t;

    logic [2:0]        pins_s;
    logic              cs_s, sclk_s, sdi_s;
    edge_t             prv_d, prv_q;
    logic              cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic              frame_active;
    logic              sdo_bit;
    logic [WORD_W-1:0] idr_next;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  bit_cnt;

    sfi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdi}),
        .sync_o  (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    always_comb begin
        prv_d.cs   = cs_s;
        prv_d.sclk = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_q.cs   <= 1'b1;
            prv_q.sclk <= 1'b0;
        end else begin
            prv_q <= prv_d;
        end
    end

    assign cs_fall   =  prv_q.cs   & ~cs_s;
    assign cs_rise   = ~prv_q.cs   &  cs_s;
    assign sclk_rise = ~prv_q.sclk &  sclk_s;
    assign sclk_fall =  prv_q.sclk & ~sclk_s;

    sfi_shift #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cs_fall),
        .active    (frame_active),
        .cap       (sclk_rise),
        .launch    (sclk_fall),
        .sdi       (sdi_s),
        .load_word (out_word),
        .sdo_bit   (sdo_bit),
        .idr_next  (idr_next),
        .cnt_next  (cnt_next),
        .cnt_q_o   (bit_cnt)
    );

    sfi_frame_ctl #(
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W),
        .READY_DLY (READY_DLY)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cnt_next  (cnt_next),
        .idr_next  (idr_next),
        .active    (frame_active),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .rdy       (rdy)
    );

    assign sdo_oe = frame_active;
    assign sdo    = frame_active & sdo_bit;

endmodule

// File: rtl/sfi_cmd_frame_chk.sv
module sfi_cmd_frame_chk #(
    parameter int unsigned WORD_W = 22,
    parameter int unsigned CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo_oe,
    input logic             rdy,
    input logic             cmd_valid,
    input logic [CNT_W-1:0] cnt
);

    // R11
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8
    frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !rdy);

    // R5
    cmd_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (!sdo_oe && !rdy));

    // R6
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cnt >= CNT_W'(WORD_W)));

    // R7
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt >= $past(cnt)));

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> sdo_oe);

endmodule

bind sfi_cmd_frame sfi_cmd_frame_chk #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo_oe    (sdo_oe),
    .rdy       (rdy),
    .cmd_valid (cmd_valid),
    .cnt       (bit_cnt)
);

// File: tb/test_sfi_cmd_frame.sv
module test_sfi_cmd_frame;

    localparam int unsigned W   = 22;
    localparam int unsigned DLY = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [W-1:0] out_word = '0;
    logic         sdo, sdo_oe, rdy, cmd_valid;
    logic [W-1:0] cmd_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [W-1:0] exp_q[$];
    logic prev_vld = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sfi_cmd_frame #(.WORD_W(W), .SYNC_STAGES(2), .READY_DLY(DLY)) i_sfi_cmd_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .out_word  (out_word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .rdy       (rdy),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every command strobe
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cmd_valid) begin
                n_chk++;
                if (prev_vld) begin
                    n_fail++;
                    $display("FAIL R11: actual strobe length 2 expected 1");
                end else if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6: actual unexpected command %h expected none", cmd_word);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    if (cmd_word !== e) begin
                        n_fail++;
                        $display("FAIL R5/R7/R9: actual %h expected %h", cmd_word, e);
                    end
                end
            end
            prev_vld <= cmd_valid;
        end
    end

    // Driver: one frame of n clocks; stream bit sent at clock i is bits[n-1-i]
    task automatic frame(input logic [W-1:0] ow, input logic [63:0] bits, input int n,
                         input bit coincide, input bit swap_word);
        out_word = ow;
        if (n >= W) exp_q.push_back(bits[W-1:0]);
        cs_n = 1'b0;
        wait_cyc(8);
        check("R2 oe", W'(sdo_oe), W'(1));
        check("R2 rdy", W'(rdy), W'(0));
        for (int i = 0; i < n; i++) begin
            sdi = bits[n-1-i];
            if (swap_word && i == 3) out_word = ~ow;   // R10
            wait_cyc(6);
            if (i == 0)      check("R2", W'(sdo), W'(ow[W-1]));
            else if (i < W)  check("R3/R6/R10", W'(sdo), W'(ow[W-1-i]));
            else             check("R3 tail", W'(sdo), W'(0));
            wait_cyc(2);
            sclk = 1'b1;
            if (coincide && i == n-1) cs_n = 1'b1;   // R9
            wait_cyc(8);
            if (!(coincide && i == n-1)) sclk = 1'b0;
        end
        if (!coincide) cs_n = 1'b1;
        wait_cyc(6);
        sclk = 1'b0;
        check("R8 oe", W'(sdo_oe), W'(0));
        check("R8 rdy low", W'(rdy), W'(0));
        wait_cyc(DLY + 8);
        check("R8 rdy high", W'(rdy), W'(1));
    endtask

    initial begin
        wait_cyc(3);
        // R1
        check("R1 rdy", W'(rdy), W'(1));
        check("R1 oe", W'(sdo_oe), W'(0));
        check("R1 sdo", W'(sdo), W'(0));
        check("R1 vld", W'(cmd_valid), W'(0));
        rst_n = 1'b1;
        wait_cyc(4);

        // R4 R5: exact frames, distinct patterns
        frame(22'h2A5A5A, 64'h00000000_00312345, 22, 1'b0, 1'b0);
        frame(22'h155555, 64'h00000000_003FFFFF, 22, 1'b0, 1'b0);
        frame(22'h3C0F0F, 64'h00000000_00200001, 22, 1'b0, 1'b0);
        // R6: short frames read the upper bits, no command
        frame(22'h3FFFFF, 64'h00000000_0002ABCD, 18, 1'b0, 1'b0);
        frame(22'h200000, 64'h00000000_00000001, 1,  1'b0, 1'b0);
        frame(22'h1ABCDE, 64'h00000000_001FFFFF, 21, 1'b0, 1'b0);
        // R7: long frames, second one beyond the counter range
        frame(22'h0F0F0F, 64'h00000000_2B3C4D5E, 30, 1'b0, 1'b0);
        frame(22'h123456, 64'h000000A5_5A6B7C8D, 40, 1'b0, 1'b0);
        // R9: last capture edge together with chip-select release
        frame(22'h0ABCDE, 64'h00000000_00254321, 22, 1'b1, 1'b0);
        // R10: output word changes while the frame is open
        frame(22'h2C3D4E, 64'h00000000_00111111, 22, 1'b0, 1'b1);

        wait_cyc(10);
        check("R5/R7 queue drained", W'(exp_q.size()), W'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule